// File: doc/BRIEF.md
# Point-to-Point Stream Link

This block joins a producing process to a consuming process inside one clock domain. The producer side offers a word with an offer strobe and sees an accept signal. The consumer side sees a data-available signal with the word and answers with a take strobe. Every word carries an extra close bit, which the producer sets on the final word of a stream. Once the consumer has taken that word, a sticky end-of-stream flag tells it that nothing more will arrive.

A build-time parameter selects one of three transfer disciplines.
- **Rendezvous:** there is no storage. A word moves only in a cycle where both ends are engaged, and whichever end arrives first waits.
- **Valid-tag:** the producer is never stalled. Each offered word is registered and shown to the consumer for exactly one cycle, and the consumer cannot push back.
- **Buffered:** a FIFO of parameterized depth decouples the ends. A push and a pop in the same cycle on a full FIFO are both accepted, so the link sustains one word per clock.

Top module: `stream_link`

## Requirements
- R1: After reset in any mode, the consumer data-available output and the end-of-stream flag are low. In valid-tag and buffered modes the producer accept output is high.
- R2: In rendezvous mode, the consumer data-available output follows the producer offer in the same cycle, and the producer accept follows the consumer take. The word and close bit pass through unchanged. A word is transferred only in a cycle where offer and take are both high.
- R3: In valid-tag mode, producer accept is always high. A word offered in cycle N is shown with data-available high in cycle N+1 only. The consumer take input has no effect.
- R4: In buffered mode, words leave in the order they were accepted. Data-available is high exactly while the FIFO holds at least one word.
- R5: In buffered mode with DEPTH words stored and take low, producer accept is low and an offered word is not stored.
- R6: In buffered mode with the FIFO full, a cycle with take high keeps producer accept high. The new word is stored while the head word leaves, and the occupancy stays at DEPTH.
- R7: The close bit appears on rd_last together with its word. The end-of-stream flag rises in the cycle after the word that carries close=1 is transferred to the consumer.
- R8: Once raised, the end-of-stream flag stays high until reset, whatever the later traffic.
- R9: Synchronous active-low reset in the middle of a stream empties the FIFO, drops any pending valid-tag word, and clears the end-of-stream flag.
- R10: In buffered mode, a word accepted into an empty FIFO is available to the consumer in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Producer offers a word this cycle |
| wr_data | input | DATA_W | Producer word |
| wr_last | input | 1 | Close bit sent with the producer word |
| wr_rdy | output | 1 | Link accepts the offered word this cycle |
| rd_en | input | 1 | Consumer takes the presented word this cycle |
| rd_rdy | output | 1 | A word is presented to the consumer |
| rd_data | output | DATA_W | Presented word |
| rd_last | output | 1 | Close bit of the presented word |
| rd_eos | output | 1 | Sticky end-of-stream flag |

## Verification
Result timing depends on the mode.
- **Rendezvous:** the consumer outputs are due in the same cycle as the offer, and the producer accept in the same cycle as the take.
- **Valid-tag:** the consumer sees a word one clock after it was offered, for one cycle only.
- **Buffered:** a word becomes available one clock after it is accepted.
- **All modes:** the end-of-stream flag follows one clock after the closing transfer.

The bench drives inputs just after the falling edge and samples one time unit later. That sample therefore sees the state left by the last rising edge together with the new inputs. Reference models update their expected state only after the sample, so each comparison lines up with the register stage it checks.

// File: rtl/stream_pkg.sv
// Shared definitions for the stream link.
// Assumes: one clock domain; one close bit appended above the payload.
package stream_pkg;

    // Transfer discipline chosen per link instance.
    typedef enum logic [1:0] {
        LINK_RENDEZVOUS = 2'd0,
        LINK_VALID_TAG  = 2'd1,
        LINK_BUFFERED   = 2'd2
    } link_mode_e;

endpackage

// File: rtl/stream_tag_stage.sv
// Valid-tag stage: registers an offered word and shows it for one cycle.
// Assumes: the consumer captures in that cycle and gives no back-pressure.
module stream_tag_stage #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_vld,
    output logic [WORD_W-1:0] out_word
);

    logic              tag_q;
    logic [WORD_W-1:0] word_q;

    // Tag register: high for exactly the cycle after each offer.
    always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= 1'b0;
        else        tag_q <= in_vld;
    end

    // Word register: load only on an offer.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (in_vld) word_q <= in_word;
    end

    assign out_vld  = tag_q;
    assign out_word = word_q;

endmodule

// File: rtl/stream_fifo.sv
// Buffered handshake store: a circular FIFO of DEPTH words.
// Assumes DEPTH >= 2. A pop on a full FIFO frees the slot for a
// push in the same cycle.
module stream_fifo #(
    parameter int WORD_W = 9,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_rdy,
    input  logic              out_pop,
    output logic              out_vld,
    output logic [WORD_W-1:0] out_word
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] slots [DEPTH];
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;
    logic [CW-1:0]     fill;
    logic              full;
    logic              empty;
    logic              push;
    logic              pop;

    // Advance a slot index with wrap at DEPTH.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Status and transfer qualification.
    always_comb begin
        full   = (fill == CW'(DEPTH));
        empty  = (fill == '0);
        pop    = out_pop && !empty;
        in_rdy = !full || out_pop;
        push   = in_vld && in_rdy;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // Slot storage write.
    always_ff @(posedge clk) begin
        if (push) slots[wptr] <= in_word;
    end

    assign out_vld  = !empty;
    assign out_word = slots[rptr];

endmodule

// File: rtl/stream_reader.sv
// Consumer end: splits payload and close bit, keeps the end-of-stream flag.
// Assumes take is high only in a cycle where a transfer happens.
module stream_reader #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_vld,
    input  logic [DATA_W:0]   ch_word,
    input  logic              take,
    output logic              rd_rdy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              rd_eos
);

    logic eos_q;

    // Sticky flag: set by a transfer of a closing word, cleared by reset only.
    always_ff @(posedge clk) begin
        if (!rst_n)                    eos_q <= 1'b0;
        else if (take && ch_word[DATA_W]) eos_q <= 1'b1;
    end

    assign rd_rdy  = ch_vld;
    assign rd_data = ch_word[DATA_W-1:0];
    assign rd_last = ch_word[DATA_W];
    assign rd_eos  = eos_q;

endmodule

// File: rtl/stream_link.sv
// Stream link top: producer end, mode-selected channel, consumer end.
// Assumes a single clock and synchronous active-low reset.
module stream_link
    import stream_pkg::*;
#(
    parameter link_mode_e MODE   = LINK_BUFFERED,
    parameter int         DATA_W = 8,
    parameter int         DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    output logic              wr_rdy,
    input  logic              rd_en,
    output logic              rd_rdy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              rd_eos
);

    localparam int WORD_W = DATA_W + 1;

    logic [WORD_W-1:0] in_word;
    logic              ch_vld;
    logic [WORD_W-1:0] ch_word;
    logic              take;

    assign in_word = {wr_last, wr_data};

    generate
        if (MODE == LINK_RENDEZVOUS) begin : g_rdv
            // Direct pass-through: the transfer needs both ends engaged.
            assign ch_vld  = wr_en;
            assign ch_word = in_word;
            assign wr_rdy  = rd_en;
            assign take    = wr_en && rd_en;
        end else if (MODE == LINK_VALID_TAG) begin : g_vtag
            logic rd_en_unused;
            assign rd_en_unused = rd_en;
            assign wr_rdy = 1'b1;
            stream_tag_stage #(.WORD_W(WORD_W)) u_tag (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_vld   (wr_en),
                .in_word  (in_word),
                .out_vld  (ch_vld),
                .out_word (ch_word)
            );
            assign take = ch_vld;
        end else begin : g_buf
            stream_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_vld   (wr_en),
                .in_word  (in_word),
                .in_rdy   (wr_rdy),
                .out_pop  (rd_en),
                .out_vld  (ch_vld),
                .out_word (ch_word)
            );
            assign take = ch_vld && rd_en;
        end
    endgenerate

    stream_reader #(.DATA_W(DATA_W)) u_reader (
        .clk     (clk),
        .rst_n   (rst_n),
        .ch_vld  (ch_vld),
        .ch_word (ch_word),
        .take    (take),
        .rd_rdy  (rd_rdy),
        .rd_data (rd_data),
        .rd_last (rd_last),
        .rd_eos  (rd_eos)
    );

endmodule

// File: rtl/stream_link_checker.sv
// Property checker for stream_link, attached with bind.
// Tracks buffered occupancy with its own counter, independent of the FIFO.
module stream_link_checker
    import stream_pkg::*;
#(
    parameter link_mode_e MODE   = LINK_BUFFERED,
    parameter int         DATA_W = 8,
    parameter int         DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              wr_rdy,
    input  logic              rd_en,
    input  logic              rd_rdy,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_last,
    input  logic              rd_eos
);

    localparam int CW = $clog2(DEPTH + 1) + 1;

    logic chk_unused;
    assign chk_unused = ^{wr_data, wr_last, rd_data};

    AST_EOS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_eos |=> rd_eos); // R8

    AST_EOS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_eos) |-> $past(rd_rdy && rd_last && (MODE == LINK_VALID_TAG || rd_en))); // R7

    generate
        if (MODE == LINK_RENDEZVOUS) begin : g_rdv
            AST_RDV_BOTH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_rdy) |-> (rd_rdy && rd_en && rd_data == wr_data)); // R2
        end else if (MODE == LINK_VALID_TAG) begin : g_vtag
            AST_VTAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                rd_rdy |-> ($past(wr_en) && rd_data == $past(wr_data))); // R3
            AST_VTAG_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
                wr_rdy); // R3
        end else begin : g_buf
            logic [CW-1:0] occ;
            // Occupancy seen from the ports.
            always_ff @(posedge clk) begin
                if (!rst_n) occ <= '0;
                else occ <= occ + CW'(wr_en && wr_rdy) - CW'(rd_en && rd_rdy);
            end
            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                occ <= CW'(DEPTH)); // R5
            AST_BUF_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
                rd_rdy == (occ != '0)); // R4
            AST_BUF_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_rdy |-> (occ == CW'(DEPTH) && !rd_en)); // R5
            AST_BUF_FULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                (occ == CW'(DEPTH) && rd_en) |-> wr_rdy); // R6
        end
    endgenerate

endmodule

bind stream_link stream_link_checker #(
    .MODE(MODE), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_stream_link_checker (.*);

// File: tb/test_stream_link.sv
// Bench for stream_link: one instance per mode, reference models per mode.
module test_stream_link;
    import stream_pkg::*;

    localparam int DW    = 8;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Rendezvous instance signals.
    logic rv_wr_en = 0, rv_wr_last = 0, rv_rd_en = 0;
    logic [DW-1:0] rv_wr_data = '0;
    logic rv_wr_rdy, rv_rd_rdy, rv_rd_last, rv_rd_eos;
    logic [DW-1:0] rv_rd_data;
    // Valid-tag instance signals.
    logic vt_wr_en = 0, vt_wr_last = 0, vt_rd_en = 0;
    logic [DW-1:0] vt_wr_data = '0;
    logic vt_wr_rdy, vt_rd_rdy, vt_rd_last, vt_rd_eos;
    logic [DW-1:0] vt_rd_data;
    // Buffered instance signals.
    logic bf_wr_en = 0, bf_wr_last = 0, bf_rd_en = 0;
    logic [DW-1:0] bf_wr_data = '0;
    logic bf_wr_rdy, bf_rd_rdy, bf_rd_last, bf_rd_eos;
    logic [DW-1:0] bf_rd_data;

    stream_link #(.MODE(LINK_RENDEZVOUS), .DATA_W(DW), .DEPTH(DEPTH)) i_stream_link_rdv (
        .clk(clk), .rst_n(rst_n), .wr_en(rv_wr_en), .wr_data(rv_wr_data),
        .wr_last(rv_wr_last), .wr_rdy(rv_wr_rdy), .rd_en(rv_rd_en), .rd_rdy(rv_rd_rdy),
        .rd_data(rv_rd_data), .rd_last(rv_rd_last), .rd_eos(rv_rd_eos));

    stream_link #(.MODE(LINK_VALID_TAG), .DATA_W(DW), .DEPTH(DEPTH)) i_stream_link_vtag (
        .clk(clk), .rst_n(rst_n), .wr_en(vt_wr_en), .wr_data(vt_wr_data),
        .wr_last(vt_wr_last), .wr_rdy(vt_wr_rdy), .rd_en(vt_rd_en), .rd_rdy(vt_rd_rdy),
        .rd_data(vt_rd_data), .rd_last(vt_rd_last), .rd_eos(vt_rd_eos));

    stream_link #(.MODE(LINK_BUFFERED), .DATA_W(DW), .DEPTH(DEPTH)) i_stream_link (
        .clk(clk), .rst_n(rst_n), .wr_en(bf_wr_en), .wr_data(bf_wr_data),
        .wr_last(bf_wr_last), .wr_rdy(bf_wr_rdy), .rd_en(bf_rd_en), .rd_rdy(bf_rd_rdy),
        .rd_data(bf_rd_data), .rd_last(bf_rd_last), .rd_eos(bf_rd_eos));

    // Reference model state.
    bit rv_eos = 0;
    bit vt_eos = 0, vt_prev_en = 0, vt_prev_last = 0;
    logic [DW-1:0] vt_prev_data = '0;
    bit bf_eos = 0;
    logic [DW:0] bq[$];

    // Compare one value and record the outcome.
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FIL%s %s: actual %0d expected %0d", "", req, act, exp);
        end
    endtask

    // Print the summary once and stop.
    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Hold reset for one cycle with idle inputs and clear all models.
    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rv_wr_en = 0; rv_rd_en = 0; vt_wr_en = 0; vt_rd_en = 0; bf_wr_en = 0; bf_rd_en = 0;
        @(negedge clk);
        rst_n = 1'b1;
        rv_eos = 0; vt_eos = 0; vt_prev_en = 0; bf_eos = 0;
        bq.delete();
    endtask

    // One rendezvous cycle: outputs due in the same cycle.
    task automatic rv_step(input logic en, input logic last, input logic [DW-1:0] d,
                           input logic ren, input string req);
        @(negedge clk);
        rv_wr_en = en; rv_wr_last = last; rv_wr_data = d; rv_rd_en = ren;
        #1;
        check(req, rv_rd_rdy, en);
        check(req, rv_wr_rdy, ren);
        if (en) begin
            check(req, rv_rd_data, d);
            check(req, rv_rd_last, last);
        end
        check(req, rv_rd_eos, rv_eos);
        if (en && ren && last) rv_eos = 1;
    endtask

    // One valid-tag cycle: outputs reflect the previous cycle's offer.
    task automatic vt_step(input logic en, input logic last, input logic [DW-1:0] d,
                           input logic ren, input string req);
        @(negedge clk);
        vt_wr_en = en; vt_wr_last = last; vt_wr_data = d; vt_rd_en = ren;
        #1;
        check(req, vt_rd_rdy, vt_prev_en);
        check(req, vt_wr_rdy, 1);
        if (vt_prev_en) begin
            check(req, vt_rd_data, vt_prev_data);
            check(req, vt_rd_last, vt_prev_last);
        end
        check(req, vt_rd_eos, vt_eos);
        if (vt_prev_en && vt_prev_last) vt_eos = 1;
        vt_prev_en = en; vt_prev_last = last; vt_prev_data = d;
    endtask

    // One buffered cycle: compare against the queue model, then update it.
    task automatic bf_step(input logic en, input logic last, input logic [DW-1:0] d,
                           input logic ren, input string req);
        bit avail, acc;
        @(negedge clk);
        bf_wr_en = en; bf_wr_last = last; bf_wr_data = d; bf_rd_en = ren;
        #1;
        avail = (bq.size() != 0);
        acc   = (bq.size() < DEPTH) || ren;
        check(req, bf_rd_rdy, avail);
        check(req, bf_wr_rdy, acc);
        if (avail) begin
            check(req, bf_rd_data, bq[0][DW-1:0]);
            check(req, bf_rd_last, bq[0][DW]);
        end
        check(req, bf_rd_eos, bf_eos);
        if (ren && avail) begin
            if (bq[0][DW]) bf_eos = 1;
            void'(bq.pop_front());
        end
        if (en && acc) bq.push_back({last, d});
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every mode.
        #1;
        check("R1", rv_rd_rdy, 0); check("R1", rv_rd_eos, 0);
        check("R1", vt_rd_rdy, 0); check("R1", vt_wr_rdy, 1); check("R1", vt_rd_eos, 0);
        check("R1", bf_rd_rdy, 0); check("R1", bf_wr_rdy, 1); check("R1", bf_rd_eos, 0);

        // R2: rendezvous under random offer and take patterns.
        for (int i = 0; i < 300; i++)
            rv_step(1'($urandom % 2), 1'b0, 8'($urandom), 1'($urandom % 2), "R2");
        // R2/R7: closing word offered without take does not move.
        rv_step(1, 1, 8'hA5, 0, "R2");
        rv_step(1, 1, 8'hA5, 1, "R7");
        // R8: flag stays through later traffic.
        for (int i = 0; i < 20; i++)
            rv_step(1'($urandom % 2), 1'($urandom % 2), 8'($urandom), 1'($urandom % 2), "R8");
        rv_step(0, 0, 0, 0, "R8");

        // R3: valid-tag with random take ignored.
        for (int i = 0; i < 300; i++)
            vt_step(1'($urandom % 2), 1'b0, 8'($urandom), 1'($urandom % 2), "R3");
        vt_step(1, 1, 8'h3C, 0, "R7");
        vt_step(0, 0, 0, 0, "R7");
        vt_step(0, 0, 0, 0, "R7");
        for (int i = 0; i < 20; i++)
            vt_step(1'($urandom % 2), 1'($urandom % 2), 8'($urandom), 1'($urandom % 2), "R8");

        // R10: word into empty FIFO is available next cycle.
        bf_step(1, 0, 8'h11, 0, "R10");
        bf_step(0, 0, 0, 0, "R10");
        // R5: fill to DEPTH, then offers stall.
        for (int i = 0; i < DEPTH; i++) bf_step(1, 0, 8'(8'h20 + i), 0, "R5");
        bf_step(1, 0, 8'hEE, 0, "R5");
        check("R5", int'(bq.size()), DEPTH);
        // R6: push and pop together on full.
        bf_step(1, 0, 8'h77, 1, "R6");
        bf_step(0, 0, 0, 0, "R6");
        check("R6", int'(bq.size()), DEPTH);
        // R4: random traffic with write-heavy and read-heavy phases.
        for (int ph = 0; ph < 6; ph++)
            for (int i = 0; i < 150; i++)
                bf_step(1'(($urandom % 4) < ((ph % 2) ? 1 : 3)), 1'b0, 8'($urandom),
                        1'(($urandom % 4) < ((ph % 2) ? 3 : 1)), "R4");
        // R7: close word goes through the FIFO.
        bf_step(1, 1, 8'hC1, 0, "R7");
        while (bq.size() != 0) bf_step(0, 0, 0, 1, "R7");
        bf_step(0, 0, 0, 0, "R7");
        check("R7", bf_rd_eos, 1);
        for (int i = 0; i < 20; i++)
            bf_step(1'($urandom % 2), 1'($urandom % 2), 8'($urandom), 1'($urandom % 2), "R8");

        // R9: reset mid-stream with words stored and pending tag.
        bf_step(1, 0, 8'h51, 0, "R9");
        bf_step(1, 0, 8'h52, 0, "R9");
        @(negedge clk);
        vt_wr_en = 1; vt_wr_last = 1;
        apply_reset();
        #1;
        check("R9", bf_rd_rdy, 0); check("R9", bf_rd_eos, 0); check("R9", bf_wr_rdy, 1);
        check("R9", vt_rd_rdy, 0); check("R9", vt_rd_eos, 0); check("R9", rv_rd_eos, 0);
        bf_step(0, 0, 0, 1, "R9");
        vt_step(0, 0, 0, 0, "R9");

        finish_run();
    end

endmodule